// File: doc/BRIEF.md
# Block-Mode Serial Transmit Controller

This block sits between a host write bus and a serial output line. The host fills a 32-byte transmit store through an address window, then issues a send command. Only then are the stored bytes serialized. Each byte leaves as an asynchronous character. The character shape (data length, parity, stop count) comes from a format register. A separate bit engine provides timing through a single-cycle bit tick, one pulse per bit time.

Two levels report progress: one says the store can take a new block, the other says nothing remains to be sent. Each has an event pulse. A one-character priority register lets the host slip a single character ahead of the stored block, with its own busy flag. A reset command discards the stored block. Commands share a busy window during which further commands are dropped. A break bit forces the line low.

Top module: `tx_fifo_ctrl`

## Requirements
- R1: After reset, tx_o is 1, pool_free_o and all_sent_o are 1, and cmd_busy_o, imm_busy_o, irq_pool_o and irq_all_o are 0. The format is 8 data bits, no parity, one stop bit.
- R2: Writes to addresses 0x00–0x1F append bytes to the store in write order, whatever the offset used. Writes past the 32nd byte are ignored. Writes made while a block is being sent are ignored.
- R3: Nothing is sent until a send command: a write of bit0=1 to address 0x20. A send command with an empty store, or while a block is already being sent, is ignored.
- R4: Each character starts with a 0 start bit, then the data bits LSB first, then an optional parity bit, then one or two stop bits at 1. The format register at 0x22 sets the shape:
  - bits[1:0] give the data length minus 5.
  - bit2 selects two stop bits.
  - bit3 enables parity.
  - bit4 selects odd parity (0 means even).
  - The format is sampled when each character starts.
- R5: pool_free_o falls the cycle after an accepted send command. It rises when the last stored byte moves into the shifter. irq_pool_o pulses for one cycle at that same moment.
- R6: all_sent_o is 1 exactly when the shifter is idle, no block is being sent and no priority character is outstanding, with one cycle of delay. irq_all_o pulses for one cycle each time all_sent_o rises.
- R7: A write to 0x21 sets imm_busy_o, unless it is already set, in which case the write is ignored. The character is sent before any remaining stored byte. imm_busy_o clears at the bit tick that ends its last stop bit.
- R8: A write of bit1=1 to 0x20 is a reset command. It empties the store and cancels a pending block. Reset wins over send if both bits are set.
- R9: An accepted command sets cmd_busy_o for CMD_CYCLES (default 3) cycles. Command writes during that window are ignored.
- R10: Format bit5 (break) holds tx_o at 0 for as long as it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 6 | Host write address (store window, command, priority char, format) |
| wr_data_i | input | 8 | Host write data |
| bit_tick_i | input | 1 | One-cycle pulse per bit time from the baud engine |
| tx_o | output | 1 | Serial line, idle high |
| pool_free_o | output | 1 | Store may be loaded with a new block |
| cmd_busy_o | output | 1 | A command is executing; new commands are dropped |
| imm_busy_o | output | 1 | Priority character not yet fully sent |
| all_sent_o | output | 1 | Store, shifter and priority slot all empty |
| irq_pool_o | output | 1 | One-cycle pulse when the store frees up |
| irq_all_o | output | 1 | One-cycle pulse when everything has been sent |

## Verification
The assertions assume the following about the inputs:
- The bit tick is a pulse with many clocks between pulses.
- Reset is asserted before the first edge.
- The host drives at most one write per cycle.

The bench creates a tick every fourth clock. It reads the line in the middle of each bit period and decodes characters against a queue of expected frames. It waits for cmd_busy_o to drop before every command it means to be accepted. It issues back-to-back commands only where it is testing the busy window. It changes the format only while the line is idle. Random blocks use random lengths, data and formats, sometimes with a priority character.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int FRAME_W = 12;
  localparam int LEN_W   = 4;
  localparam int CMD_XF_BIT  = 0;
  localparam int CMD_RES_BIT = 1;

  typedef struct packed {
    logic       brk;
    logic       odd;
    logic       par_en;
    logic       two_stop;
    logic [1:0] len_code;
  } fmt_t;

  localparam fmt_t FMT_RESET = '{brk: 1'b0, odd: 1'b0, par_en: 1'b0,
                                 two_stop: 1'b0, len_code: 2'd3};

  // bit 0 = start; stop bits fill the rest with 1
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [7:0] d, input fmt_t f);
    logic [FRAME_W-1:0] b;
    logic par;
    int n;
    n   = 5 + int'(f.len_code);
    b   = '1;
    b[0] = 1'b0;
    par = f.odd;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        b[1+i] = d[i];
        par    = par ^ d[i];
      end
    end
    for (int i = 6; i < FRAME_W; i++) begin
      if (f.par_en && i == n + 1) b[i] = par;
    end
    return b;
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input fmt_t f);
    return 4'd7 + 4'(f.len_code) + 4'(f.par_en) + 4'(f.two_stop);
  endfunction
endpackage

// File: rtl/tx_cmd_unit.sv
module tx_cmd_unit #(
  parameter int CMD_CYCLES = 3,
  localparam int BW = $clog2(CMD_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] data_i,
  output logic       xf_o,
  output logic       flush_o,
  output logic       busy_o
);
  import tx_fifo_pkg::*;

  logic [BW-1:0] cnt_q;
  logic          accept;

  assign accept  = wr_i && (cnt_q == '0) && (data_i[CMD_XF_BIT] || data_i[CMD_RES_BIT]);
  assign flush_o = accept && data_i[CMD_RES_BIT];
  assign xf_o    = accept && data_i[CMD_XF_BIT] && !data_i[CMD_RES_BIT];
  assign busy_o  = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (accept)       cnt_q <= BW'(CMD_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // busy window only counts down; writes inside it cannot restart it
  p_busy_countdown_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tx_block_store.sv
module tx_block_store #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] push_data_i,
  input  logic       start_i,
  input  logic       flush_i,
  input  logic       pop_i,
  output logic       avail_o,
  output logic [7:0] head_o,
  output logic       pool_free_o,
  output logic       drained_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem_q [DEPTH];
  logic [CW-1:0] cnt_q, rd_q;
  logic          sending_q, drained_q;
  logic          accept_push, last_pop;

  assign accept_push = push_i && !sending_q && (cnt_q != FULL);
  assign last_pop    = pop_i && ((rd_q + 1'b1) == cnt_q);

  always_ff @(posedge clk_i) begin
    if (accept_push && !flush_i) mem_q[cnt_q[IW-1:0]] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rd_q      <= '0;
      sending_q <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      drained_q <= 1'b0;
      if (flush_i) begin
        cnt_q     <= '0;
        rd_q      <= '0;
        sending_q <= 1'b0;
      end else if (sending_q) begin
        if (last_pop) begin
          cnt_q     <= '0;
          rd_q      <= '0;
          sending_q <= 1'b0;
          drained_q <= 1'b1;
        end else if (pop_i) begin
          rd_q <= rd_q + 1'b1;
        end
      end else if (start_i && cnt_q != '0) begin
        sending_q <= 1'b1;
        rd_q      <= '0;
      end else if (accept_push) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign avail_o     = sending_q;
  assign head_o      = mem_q[rd_q[IW-1:0]];
  assign pool_free_o = !sending_q;
  assign drained_o   = drained_q;

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_frozen_while_sending_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sending_q && push_i && !flush_i) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
  p_drain_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drained_q |-> !sending_q);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import tx_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  fmt_t       fmt_i,
  input  logic       imm_pend_i,
  input  logic [7:0] imm_data_i,
  input  logic       blk_avail_i,
  input  logic [7:0] blk_data_i,
  output logic       line_o,
  output logic       idle_o,
  output logic       load_imm_o,
  output logic       pop_blk_o,
  output logic       imm_done_o
);
  logic               active_q, cur_imm_q, line_q;
  logic [LEN_W-1:0]   left_q;
  logic [FRAME_W-1:0] rest_q;
  logic               slot_free, load_any;
  logic [7:0]         ld_data;
  logic [FRAME_W-1:0] ld_frame;

  // a new frame may start on the tick that ends the previous last stop bit
  assign slot_free  = tick_i && (!active_q || left_q == '0);
  assign load_imm_o = slot_free && imm_pend_i;
  assign pop_blk_o  = slot_free && !imm_pend_i && blk_avail_i;
  assign load_any   = load_imm_o || pop_blk_o;
  assign ld_data    = imm_pend_i ? imm_data_i : blk_data_i;
  assign ld_frame   = frame_bits(ld_data, fmt_i);
  assign imm_done_o = tick_i && active_q && (left_q == '0) && cur_imm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      cur_imm_q <= 1'b0;
      line_q    <= 1'b1;
      left_q    <= '0;
      rest_q    <= '1;
    end else if (load_any) begin
      active_q  <= 1'b1;
      cur_imm_q <= load_imm_o;
      line_q    <= ld_frame[0];
      rest_q    <= {1'b1, ld_frame[FRAME_W-1:1]};
      left_q    <= frame_len(fmt_i) - 4'd1;
    end else if (tick_i && active_q) begin
      if (left_q == '0) begin
        active_q  <= 1'b0;
        cur_imm_q <= 1'b0;
        line_q    <= 1'b1;
      end else begin
        line_q <= rest_q[0];
        rest_q <= {1'b1, rest_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign line_o = line_q;
  assign idle_o = !active_q;

  p_start_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> !line_q);
  p_left_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (left_q < LEN_W'(FRAME_W)));
endmodule

// File: rtl/tx_fifo_ctrl.sv
module tx_fifo_ctrl
  import tx_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CMD_CYCLES = 3,
  localparam int AW = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          bit_tick_i,
  output logic          tx_o,
  output logic          pool_free_o,
  output logic          cmd_busy_o,
  output logic          imm_busy_o,
  output logic          all_sent_o,
  output logic          irq_pool_o,
  output logic          irq_all_o
);
  localparam logic [AW-1:0] A_CMD = AW'(DEPTH);
  localparam logic [AW-1:0] A_IMM = AW'(DEPTH + 1);
  localparam logic [AW-1:0] A_FMT = AW'(DEPTH + 2);

  logic win_wr, cmd_wr, imm_wr, fmt_wr;
  logic xf, flush;
  logic blk_avail, pool_free, drained;
  logic [7:0] blk_head;
  logic line, sh_idle, load_imm, pop_blk, imm_done;
  fmt_t fmt_q;
  logic imm_busy_q, imm_pend_q;
  logic [7:0] imm_data_q;
  logic all_sent_q, irq_all_q, quiet;

  assign win_wr = wr_en_i && !wr_addr_i[AW-1];
  assign cmd_wr = wr_en_i && (wr_addr_i == A_CMD);
  assign imm_wr = wr_en_i && (wr_addr_i == A_IMM);
  assign fmt_wr = wr_en_i && (wr_addr_i == A_FMT);

  tx_cmd_unit #(.CMD_CYCLES(CMD_CYCLES)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i(cmd_wr), .data_i(wr_data_i[1:0]),
    .xf_o(xf), .flush_o(flush), .busy_o(cmd_busy_o)
  );

  tx_block_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(win_wr), .push_data_i(wr_data_i),
    .start_i(xf), .flush_i(flush), .pop_i(pop_blk),
    .avail_o(blk_avail), .head_o(blk_head),
    .pool_free_o(pool_free), .drained_o(drained)
  );

  tx_frame_shifter u_shift (
    .clk_i, .rst_ni,
    .tick_i(bit_tick_i), .fmt_i(fmt_q),
    .imm_pend_i(imm_pend_q), .imm_data_i(imm_data_q),
    .blk_avail_i(blk_avail), .blk_data_i(blk_head),
    .line_o(line), .idle_o(sh_idle),
    .load_imm_o(load_imm), .pop_blk_o(pop_blk), .imm_done_o(imm_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q      <= FMT_RESET;
      imm_busy_q <= 1'b0;
      imm_pend_q <= 1'b0;
      imm_data_q <= '0;
    end else begin
      if (fmt_wr) fmt_q <= fmt_t'(wr_data_i[5:0]);
      if (imm_wr && !imm_busy_q) begin
        imm_busy_q <= 1'b1;
        imm_pend_q <= 1'b1;
        imm_data_q <= wr_data_i;
      end else begin
        if (load_imm) imm_pend_q <= 1'b0;
        if (imm_done) imm_busy_q <= 1'b0;
      end
    end
  end

  assign quiet = sh_idle && pool_free && !imm_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_sent_q <= 1'b1;
      irq_all_q  <= 1'b0;
    end else begin
      all_sent_q <= quiet;
      irq_all_q  <= quiet && !all_sent_q;
    end
  end

  assign tx_o        = line & ~fmt_q.brk;
  assign pool_free_o = pool_free;
  assign imm_busy_o  = imm_busy_q;
  assign all_sent_o  = all_sent_q;
  assign irq_pool_o  = drained;
  assign irq_all_o   = irq_all_q;

  p_pool_irq_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pool_o |-> pool_free_o);
  p_all_irq_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_all_o |-> all_sent_o);
  p_imm_clear_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(imm_busy_q) |-> $past(bit_tick_i));
  p_imm_pend_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_pend_q |-> imm_busy_q);
endmodule

// File: tb/tx_fifo_ctrl_test.sv
module tx_fifo_ctrl_test;
  localparam int DEPTH = 32;
  localparam logic [5:0] A_CMD = 6'h20, A_IMM = 6'h21, A_FMT = 6'h22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, bit_tick = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic tx, pool_free, cmd_busy, imm_busy, all_sent, irq_pool, irq_all;

  always #5 clk = ~clk;

  tx_fifo_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .bit_tick_i(bit_tick), .tx_o(tx),
    .pool_free_o(pool_free), .cmd_busy_o(cmd_busy), .imm_busy_o(imm_busy),
    .all_sent_o(all_sent), .irq_pool_o(irq_pool), .irq_all_o(irq_all)
  );

  int n_chk = 0, n_bad = 0, pool_irqs = 0, all_irqs = 0, phase = 0;
  bit tick_en = 0, dec_en = 1;
  int dstate = 0, dcnt = 0, dlen = 0;
  logic [11:0] dsamp, dexp;
  logic [13:0] exp_q[$];
  logic [13:0] pend_q[$];
  logic [5:0] cur_fmt = 6'h03;

  function automatic int b_len(input logic [5:0] f);
    return 1 + (5 + int'(f[1:0])) + int'(f[3]) + 1 + int'(f[2]);
  endfunction

  function automatic logic [11:0] b_bits(input logic [7:0] d, input logic [5:0] f);
    logic [11:0] v; int n; bit p;
    n = 5 + int'(f[1:0]); v = '1; v[0] = 1'b0; p = f[4];
    for (int i = 0; i < n; i++) begin v[1+i] = d[i]; p = p ^ d[i]; end
    if (f[3]) v[1+n] = p;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [13:0] e;
    logic [11:0] m;
    if (irq_pool) pool_irqs++;
    if (irq_all) all_irqs++;
    phase = (phase + 1) % 4;
    bit_tick = tick_en && phase == 0;
    if (tick_en && dec_en && phase == 2) begin
      if (dstate == 0) begin
        if (tx == 1'b0) begin
          if (exp_q.size() == 0) chk(0, "R3", "unexpected start bit", 0, 1);
          else begin
            e = exp_q.pop_front();
            dexp = b_bits(e[7:0], e[13:8]);
            dlen = b_len(e[13:8]);
            dsamp = '1; dsamp[0] = 1'b0; dcnt = 1; dstate = 1;
          end
        end
      end else begin
        dsamp[dcnt] = tx;
        dcnt++;
        if (dcnt == dlen) begin
          m = 12'((13'd1 << dlen) - 13'd1);
          chk((dsamp & m) == (dexp & m), "R4", "frame bits (R2 order)", int'(dsamp & m), int'(dexp & m));
          dstate = 0;
        end
      end
    end
  end

  task automatic host_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_cmd();
    while (cmd_busy) @(negedge clk);
  endtask

  task automatic set_fmt(input logic [5:0] f);
    host_wr(A_FMT, {2'b00, f});
    cur_fmt = f;
  endtask

  task automatic load(input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      host_wr({1'b0, i[4:0]}, d);
      if (i < DEPTH) pend_q.push_back({cur_fmt, d});
    end
  endtask

  task automatic commit();
    while (pend_q.size() != 0) exp_q.push_back(pend_q.pop_front());
  endtask

  task automatic send_cmd();
    wait_cmd(); host_wr(A_CMD, 8'h01);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(all_sent && exp_q.size() == 0 && dstate == 0));
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pi;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx == 1'b1, "R1", "tx idle", tx, 1);
    chk(pool_free == 1'b1, "R1", "pool_free", pool_free, 1);
    chk(all_sent == 1'b1, "R1", "all_sent", all_sent, 1);
    chk(!cmd_busy && !imm_busy, "R1", "busy flags", {cmd_busy, imm_busy}, 0);
    chk(!irq_pool && !irq_all, "R1", "irqs", {irq_pool, irq_all}, 0);

    // R3: loaded bytes wait for the send command; R5/R6 events
    tick_en = 1;
    load(4);
    repeat (120) @(negedge clk);
    chk(pool_free == 1'b1, "R3", "no send before command", pool_free, 1);
    chk(pool_irqs == 0, "R5", "no pool irq yet", pool_irqs, 0);
    commit();
    send_cmd();
    chk(pool_free == 1'b0, "R5", "pool busy after send", pool_free, 0);
    chk(cmd_busy == 1'b1, "R9", "cmd busy after command", cmd_busy, 1);
    repeat (10) @(negedge clk);
    chk(all_sent == 1'b0, "R6", "all_sent low while sending", all_sent, 0);
    wait_done();
    chk(pool_irqs == 1, "R5", "pool irq count", pool_irqs, 1);
    chk(all_irqs == 1, "R6", "all_sent irq count", all_irqs, 1);
    chk(pool_free == 1'b1, "R5", "pool free after drain", pool_free, 1);

    // R9: reset command right after send is dropped
    tick_en = 0;
    load(2);
    wait_cmd();
    host_wr(A_CMD, 8'h01);
    host_wr(A_CMD, 8'h02);
    wait_cmd();
    chk(pool_free == 1'b0, "R9", "reset ignored in busy window", pool_free, 0);
    commit();
    tick_en = 1;
    wait_done();

    // R8: reset empties store; following send on empty store ignored (R3)
    tick_en = 0;
    pi = pool_irqs;
    load(3);
    pend_q.delete();
    wait_cmd(); host_wr(A_CMD, 8'h02);
    send_cmd();
    wait_cmd();
    chk(pool_free == 1'b1, "R3", "send on empty store ignored (R8 flush)", pool_free, 1);
    tick_en = 1;
    repeat (80) @(negedge clk);
    chk(pool_irqs == pi, "R8", "no drain after flush", pool_irqs, pi);
    tick_en = 0;
    load(2);
    send_cmd();
    commit();
    tick_en = 1;
    wait_done();

    // R7: priority char jumps ahead of a pending block; second write ignored
    tick_en = 0;
    load(3);
    send_cmd();
    host_wr(A_IMM, 8'hA5);
    chk(imm_busy == 1'b1, "R7", "imm busy set", imm_busy, 1);
    host_wr(A_IMM, 8'h3C);
    exp_q.push_back({cur_fmt, 8'hA5});
    commit();
    tick_en = 1;
    while (imm_busy) @(negedge clk);
    chk(exp_q.size() == 3, "R7", "imm busy clears after its own frame", exp_q.size(), 3);
    wait_done();
    host_wr(A_IMM, 8'h5A);
    exp_q.push_back({cur_fmt, 8'h5A});
    wait_done();
    chk(imm_busy == 1'b0, "R7", "imm busy clear when idle", imm_busy, 0);

    // R2: 33 writes keep 32; writes during sending ignored
    tick_en = 0;
    load(33);
    send_cmd();
    commit();
    tick_en = 1;
    repeat (60) @(negedge clk);
    chk(pool_free == 1'b0, "R2", "block still sending", pool_free, 0);
    host_wr(6'h00, 8'hEE);
    wait_done();
    load(1);
    send_cmd();
    commit();
    wait_done();

    // R4: every format combination
    for (int f = 0; f < 32; f++) begin
      tick_en = 0;
      set_fmt(6'(f));
      load(3);
      send_cmd();
      commit();
      tick_en = 1;
      wait_done();
    end

    // R10: break holds the line low
    tick_en = 1; dec_en = 0;
    set_fmt(6'h23);
    chk(tx == 1'b0, "R10", "break low", tx, 0);
    repeat (20) @(negedge clk);
    chk(tx == 1'b0, "R10", "break held", tx, 0);
    set_fmt(6'h03);
    chk(tx == 1'b1, "R10", "break released", tx, 1);
    repeat (8) @(negedge clk);
    dec_en = 1;

    // random blocks
    for (int k = 0; k < 8; k++) begin
      tick_en = 0;
      set_fmt(6'($urandom) & 6'h1F);
      load(1 + int'($urandom % 32));
      send_cmd();
      if ($urandom % 2) begin
        logic [7:0] c;
        c = 8'($urandom);
        host_wr(A_IMM, c);
        exp_q.push_back({cur_fmt, c});
      end
      commit();
      tick_en = 1;
      wait_done();
    end

    chk(exp_q.size() == 0, "R2", "all expected frames seen", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule